// File: doc/BRIEF.md
# 8-bit ALU with per-operation status flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Two byte operands (taken from registers or an immediate field by logic outside the block), a 4-bit operation code and a valid strobe come in. The result byte goes out combinationally in the same cycle. A registered status byte is rewritten on the clock edge that accepts the operation. The carry held in that status byte feeds the carry-chained operations, so multi-byte add and subtract chains can be run one byte per cycle.

Each operation rewrites only its own subset of the six arithmetic flags: half-carry, sign, overflow, negative, zero and carry. Every other flag keeps its value. The sign flag is always formed as negative xor overflow, which gives the true sign of a signed result even when the operation overflowed. It is never a copy of result bit 7.

Top module: `alu8_status`

## Requirements
- R1: The status byte `status` holds, from bit 7 down to bit 0: a global-interrupt bit, a bit-store bit, H, S, V, N, Z and C. This block never writes the top two bits, which stay 0. Reset (active-low `rst_n`) clears the whole byte to 0x00.
- R2: Operation codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-carry, 4 AND, 5 OR, 6 XOR, 7 one's complement, 8 negate, 9 increment, 10 decrement, 11 set-all-ones. `result` follows the inputs in the same cycle. `status` changes only on a rising clock edge where `op_valid` is 1; with `op_valid` at 0 it keeps its value.
- R3: Add gives opa+opb and add-with-carry gives opa+opb+C. Both update H (the carry out of bit 3), V (signed overflow), N (result bit 7), Z (result is zero) and C (the carry out of bit 7).
- R4: Subtract gives opa-opb and subtract-with-carry gives opa-opb-C. H is the borrow out of bit 3, C is the borrow out of bit 7, and V is signed overflow. N and Z are updated as for add.
- R5: For subtract-with-carry, a nonzero result clears Z. A zero result leaves Z at its previous value.
- R6: Negate gives 0x00-opa. It updates H, V, N, Z and C with the subtract rules applied to 0 minus opa, so C=1 exactly when the result is nonzero and V=1 exactly when the result is 0x80.
- R7: AND, OR and XOR clear V, update N and Z, and leave C and H unchanged.
- R8: One's complement gives 0xFF-opa. It sets C to 1, clears V, updates N and Z, and leaves H unchanged.
- R9: Increment (opa+1) and decrement (opa-1) update only V, N and Z. Increment sets V only for a result of 0x80, and decrement sets V only for a result of 0x7F.
- R10: Set-all-ones gives 0xFF and changes no flag. Codes 12 to 15 pass opa to `result` and change no flag.
- R11: Whenever N or V is written, S is written as N xor V, so S equals N xor V at all times after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted on this clock edge; the status byte is updated |
| op | input | 4 | Operation code (R2) |
| opa | input | 8 | First operand, the only operand of unary operations |
| opb | input | 8 | Second operand or immediate |
| result | output | 8 | Combinational result byte |
| status | output | 8 | Registered status byte (R1) |

## Verification
The bench targets the signed boundaries 0x7F/0x80, where a design that takes V from the carry or checks the wrong edge for increment and decrement reports a wrong overflow, and a design that copies result bit 7 into S shows the wrong sign. Multi-byte subtract-with-carry chains whose low byte is zero and whose high byte is not expose a Z flag that is recomputed instead of held or cleared. Negate of 0x00 and 0x80 catches a design that inverts the borrow or misses the single overflow case. Logic, increment and one's complement operations that follow a carry-setting operation show whether C and H are overwritten when they should be kept.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int NFLAG  = 6;   // H S V N Z C, status bits 5..0

  // flag positions inside the status byte
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_AND = 4'd4,  OP_OR  = 4'd5,  OP_XOR = 4'd6,  OP_COM = 4'd7,
    OP_NEG = 4'd8,  OP_INC = 4'd9,  OP_DEC = 4'd10, OP_SER = 4'd11
  } alu_op_e;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              h;
    logic              v;
    logic              c;
  } arith_t;

  // a + b + cin with half-carry, carry and signed overflow
  function automatic arith_t add_f(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic cin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [HALF_W:0] low;
    full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    low   = {1'b0, a[HALF_W-1:0]} + {1'b0, b[HALF_W-1:0]} + {{HALF_W{1'b0}}, cin};
    o.res = full[DATA_W-1:0];
    o.c   = full[DATA_W];
    o.h   = low[HALF_W];
    o.v   = (a[DATA_W-1] == b[DATA_W-1]) && (o.res[DATA_W-1] != a[DATA_W-1]);
    return o;
  endfunction

  // a - b - bin with half-borrow, borrow and signed overflow
  function automatic arith_t sub_f(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b,
                                   input logic bin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [HALF_W:0] low;
    full  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
    low   = {1'b0, a[HALF_W-1:0]} - {1'b0, b[HALF_W-1:0]} - {{HALF_W{1'b0}}, bin};
    o.res = full[DATA_W-1:0];
    o.c   = full[DATA_W];
    o.h   = low[HALF_W];
    o.v   = (a[DATA_W-1] != b[DATA_W-1]) && (o.res[DATA_W-1] != a[DATA_W-1]);
    return o;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         h,
  output logic         v,
  output logic         c
);
  arith_t sum_r;
  arith_t dif_r;

  always_comb begin
    sum_r = add_f(x, y, cin);
    dif_r = sub_f(x, y, cin);
  end

  assign res = sub ? dif_r.res : sum_r.res;
  assign h   = sub ? dif_r.h   : sum_r.h;
  assign v   = sub ? dif_r.v   : sum_r.v;
  assign c   = sub ? dif_r.c   : sum_r.c;
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_INC:  res = a + W'(1);
      OP_DEC:  res = a - W'(1);
      OP_SER:  res = {W{1'b1}};
      default: res = a;
    endcase
  end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
  import alu8_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [NF-1:0] upd_mask,
  input  logic [NF-1:0] upd_val,
  output logic [7:0]    status
);
  logic [NF-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else if (upd_en) flags_q <= (flags_q & ~upd_mask) | (upd_val & upd_mask);
  end

  assign status = {{(8-NF){1'b0}}, flags_q};

  // R11: sign always agrees with negative xor overflow
  a_r11_sign_is_n_xor_v: assert property (@(posedge clk) disable iff (!rst_n)
    status[F_S] == (status[F_N] ^ status[F_V]));

  // R1: interrupt and bit-store positions are never written here
  a_r1_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [3:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  output logic [7:0] result,
  output logic [7:0] status
);
  alu_op_e op_e;
  assign op_e = alu_op_e'(op);

  // named internal events
  logic       is_arith, is_bool, is_step, is_com;
  logic       carry_now, zero_now;
  logic [7:0] as_x, as_y, as_res, lg_res;
  logic       as_cin, as_sub, as_h, as_v, as_c;
  logic       new_n, new_v, new_z, new_c;
  logic [NFLAG-1:0] upd_mask, upd_val;

  assign carry_now = status[F_C];
  assign is_arith  = op_e inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG};
  assign is_bool   = op_e inside {OP_AND, OP_OR, OP_XOR};
  assign is_step   = op_e inside {OP_INC, OP_DEC};
  assign is_com    = (op_e == OP_COM);

  // operand steering for the shared adder/subtractor
  always_comb begin
    as_x   = opa;
    as_y   = opb;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op_e)
      OP_ADC: as_cin = carry_now;
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = carry_now; end
      OP_NEG: begin as_x = '0; as_y = opa; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.W(DATA_W)) u_addsub (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .res(as_res), .h(as_h), .v(as_v), .c(as_c)
  );

  alu8_logic #(.W(DATA_W)) u_logic (
    .op(op_e), .a(opa), .b(opb), .res(lg_res)
  );

  assign result   = is_arith ? as_res : lg_res;
  assign zero_now = (result == '0);

  // per-operation flag values and write masks
  always_comb begin
    new_n = result[DATA_W-1];
    new_z = zero_now;
    new_c = as_c;
    new_v = 1'b0;
    upd_mask = '0;
    if (is_arith) begin
      new_v = as_v;
      if (op_e == OP_SBC) new_z = zero_now & status[F_Z];
      upd_mask = '1;
    end else if (is_bool) begin
      upd_mask[F_S] = 1'b1; upd_mask[F_V] = 1'b1;
      upd_mask[F_N] = 1'b1; upd_mask[F_Z] = 1'b1;
    end else if (is_step) begin
      new_v = (op_e == OP_INC) ? (result == 8'h80) : (result == 8'h7F);
      upd_mask[F_S] = 1'b1; upd_mask[F_V] = 1'b1;
      upd_mask[F_N] = 1'b1; upd_mask[F_Z] = 1'b1;
    end else if (is_com) begin
      new_c = 1'b1;
      upd_mask[F_S] = 1'b1; upd_mask[F_V] = 1'b1;
      upd_mask[F_N] = 1'b1; upd_mask[F_Z] = 1'b1; upd_mask[F_C] = 1'b1;
    end
    upd_val        = '0;
    upd_val[F_H]   = as_h;
    upd_val[F_S]   = new_n ^ new_v;
    upd_val[F_V]   = new_v;
    upd_val[F_N]   = new_n;
    upd_val[F_Z]   = new_z;
    upd_val[F_C]   = new_c;
  end

  alu8_flag_reg #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .upd_en(op_valid),
    .upd_mask(upd_mask), .upd_val(upd_val), .status(status)
  );

  // R10: set-all-ones leaves every flag alone
  a_r10_ser_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 4'd11) |=> $stable(status));

  // R2: no valid strobe, no flag change
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));

  // R8: one's complement forces carry high and overflow low
  a_r8_com_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 4'd7) |=> (status[F_C] && !status[F_V]));

  // R5: nonzero subtract-with-carry result clears Z
  a_r5_sbc_nonzero_clears_z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 4'd3 && result != 8'h00) |=> !status[F_Z]);

  // R7: logic ops keep carry and half-carry
  a_r7_logic_keeps_ch: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == 4'd4 || op == 4'd5 || op == 4'd6)) |=>
      (status[F_C] == $past(status[F_C]) && status[F_H] == $past(status[F_H])));

  // R9: increment from 0x7F overflows
  a_r9_inc_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == 4'd9 && opa == 8'h7F) |=> status[F_V]);
endmodule

// File: tb/tb_alu8_status.sv
`timescale 1ns/1ps
module tb_alu8_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic [7:0] result, status;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] model_st = 8'h00;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;   // 250 MHz

  alu8_status dut (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op),
                   .opa(opa), .opb(opb), .result(result), .status(status));

  function automatic int sgn(input logic [7:0] x);
    return (x >= 8'd128) ? int'(x) - 256 : int'(x);
  endfunction

  // independent reference, written with integer arithmetic
  function automatic void model(input logic [3:0] o, input logic [7:0] a, b,
                                input logic [7:0] st, output logic [7:0] r,
                                output logic [7:0] ns);
    int ci, t, sv;
    bit h, v, z, c, wr_nv, wr_c, wr_h;
    ci = int'(st[0]); ns = st; h = 0; v = 0; c = 0; wr_nv = 1; wr_c = 0; wr_h = 0;
    r = a;
    case (o)
      0, 1: begin
        if (o == 0) ci = 0;
        t = int'(a) + int'(b) + ci; r = t[7:0]; c = (t > 255);
        h = (int'(a % 16) + int'(b % 16) + ci) > 15;
        sv = sgn(a) + sgn(b) + ci; v = (sv > 127) || (sv < -128);
        wr_c = 1; wr_h = 1;
      end
      2, 3, 8: begin
        logic [7:0] x, y;
        x = (o == 8) ? 8'h00 : a; y = (o == 8) ? a : b;
        if (o != 3) ci = 0;
        t = int'(x) - int'(y) - ci; r = t[7:0]; c = (t < 0);
        h = (int'(x % 16) - int'(y % 16) - ci) < 0;
        sv = sgn(x) - sgn(y) - ci; v = (sv > 127) || (sv < -128);
        wr_c = 1; wr_h = 1;
      end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: begin r = 8'hFF - a; c = 1; wr_c = 1; end
      9: begin r = a + 8'd1; v = (a == 8'h7F); end
      10: begin r = a - 8'd1; v = (a == 8'h80); end
      11: begin r = 8'hFF; wr_nv = 0; end
      default: begin r = a; wr_nv = 0; end
    endcase
    z = (r == 8'h00);
    if (o == 3) z = z && st[1];
    if (wr_nv) begin
      ns[3] = v; ns[2] = r[7]; ns[1] = z; ns[4] = r[7] ^ v;
    end
    if (wr_c) ns[0] = c;
    if (wr_h) ns[5] = h;
  endfunction

  task automatic check(input string req, input logic [7:0] act, exp_v);
    n_checks++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
    end
  endtask

  // driver: apply one operation, check the combinational result, queue status
  task automatic drive(input string req, input logic [3:0] o,
                       input logic [7:0] a, b, input bit vld = 1);
    logic [7:0] r, ns;
    @(negedge clk);
    op = o; opa = a; opb = b; op_valid = vld;
    model(o, a, b, model_st, r, ns);
    if (!vld) ns = model_st;
    #1 check({req, " result"}, result, r);
    model_st = ns;
    exp_q.push_back(ns);
    tag_q.push_back({req, " status"});
  endtask

  // monitor: compare status after every accepting edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string s;
        e = exp_q.pop_front(); s = tag_q.pop_front();
        check(s, status, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 reset", status, 8'h00);

    drive("R3 add", 0, 8'h0F, 8'h01);           // H set
    drive("R3 add ovf", 0, 8'h7F, 8'h01);       // V, N, S=0
    drive("R3 add carry", 0, 8'hFF, 8'h01);     // C, Z, H
    drive("R3 adc", 1, 8'h10, 8'h20);           // uses C=1
    drive("R4 sub zero", 2, 8'h05, 8'h05);      // Z=1 C=0
    drive("R5 sbc zero keeps Z", 3, 8'h03, 8'h03);
    drive("R4 sub borrow", 2, 8'h00, 8'h01);    // C=1
    drive("R5 sbc nonzero", 3, 8'h05, 8'h01);   // 5-1-1=3, Z cleared
    drive("R5 sbc zero after clear", 3, 8'h00, 8'h00);
    drive("R4 sub ovf", 2, 8'h80, 8'h01);
    drive("R6 neg 0x80", 8, 8'h80, 8'h00);
    drive("R6 neg zero", 8, 8'h00, 8'h00);
    drive("R6 neg one", 8, 8'h01, 8'h00);
    drive("R7 and keeps C", 4, 8'hF0, 8'h0F);
    drive("R7 or", 5, 8'h80, 8'h01);
    drive("R7 xor", 6, 8'hAA, 8'hAA);
    drive("R8 com", 7, 8'h00, 8'h00);
    drive("R8 com ff", 7, 8'hFF, 8'h00);
    drive("R9 inc ovf", 9, 8'h7F, 8'h00);
    drive("R9 inc wrap", 9, 8'hFF, 8'h00);
    drive("R9 dec ovf", 10, 8'h80, 8'h00);
    drive("R9 dec zero", 10, 8'h01, 8'h00);
    drive("R10 ser", 11, 8'h12, 8'h34);
    drive("R10 undefined op", 13, 8'h5A, 8'hC3);
    drive("R2 no valid", 0, 8'hFF, 8'hFF, 0);
    drive("R11 sign under ovf", 2, 8'h7F, 8'hFF);
    for (int i = 0; i < 600; i++) begin
      drive("R11 random", 4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
            ($urandom_range(0, 7) != 0));
    end
    @(negedge clk); op_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule